// File: doc/BRIEF.md
# PCI Master Command Selector

This block keeps the small part of a PCI function's configuration space that governs how the function behaves as a bus master. It holds a writable cache line size and a fixed class code. For every master transfer it requests, it picks the PCI bus command. A byte-wide configuration port reads and writes registers by byte offset. Reads are combinational. Writes take effect at the next clock edge.

The request side is also combinational. The bus master logic presents a byte start address, a length in 32-bit words and a direction. The block returns a 4-bit command code and the number of words to put on the bus before the next burst must break.

Caching is in effect only when the cache line size is a non-zero power of two. In that case the block uses the line-oriented performance commands and ends bursts on line boundaries. For any other line size it falls back to plain memory reads and writes and does not split the transfer.

Top module: `pci_master_cmd_sel`

## Requirements
- R1: The cache line size register sits at byte offset 0x0C, is 8 bits wide, reads 0 after reset, and reads back the last byte written to that offset. Its value counts 32-bit words.
- R2: Configuration reads return fixed class code bytes: offset 0x0B returns the base class 0x01, offset 0x0A returns the subclass 0x00 and offset 0x09 returns the programming interface 0x00. Any offset other than 0x09 to 0x0C reads 0.
- R3: A configuration write to any offset other than 0x0C changes nothing. The cache line size and the class code bytes read back unchanged afterwards.
- R4: Caching is in effect only when the line size is a non-zero power of two. Otherwise a read gets Memory Read (4'b0110), a write gets Memory Write (4'b0111), and the burst length equals the requested length.
- R5: With caching in effect, a write gets Memory Write and Invalidate (4'b1111) when the start word address is a multiple of the line size and the length is at least one line. The burst is the length rounded down to whole lines.
- R6: With caching in effect, any other write gets Memory Write (4'b0111). Its burst is the smaller of the length and the number of words up to the next line boundary.
- R7: With caching in effect, the read burst is the smaller of the length and the words to the boundary. The command is Memory Read (4'b0110) for a one-word read, Memory Read Line (4'b1110) when the read ends within the current line, and Memory Read Multiple (4'b1100) when it runs past the line.
- R8: A zero-word request returns a burst of 0 with the basic command for its direction.
- R9: Address bits [1:0] have no effect on the command or the burst. The start word is address bits above bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ofs | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for cfg_ofs |
| req_addr | input | ADDR_W (32) | Byte start address of the transfer |
| req_len | input | LEN_W (12) | Transfer length in 32-bit words |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| cmd | output | 4 | PCI bus command code |
| burst_len | output | LEN_W (12) | Words to issue before the next break |

## Verification
The hardest case to reach is the boundary between Memory Read Line and Memory Read Multiple. It occurs only when the line size is a power of two, the start offset inside the line is non-zero, and the length lands exactly on the remaining words of the line or one past them. Random addresses and lengths almost never hit these exact edges.

The stimulus therefore programs each legal line size in turn and derives directed requests from it: an aligned full line, one word short of the boundary, exactly at the boundary and one beyond it. Random requests then cover the general space, including non-power-of-two line sizes and sizes with low address bits set.

// File: rtl/pmcs_pkg.sv
package pmcs_pkg;
   typedef enum logic [3:0] {
      CMD_MEM_RD      = 4'b0110,
      CMD_MEM_WR      = 4'b0111,
      CMD_MEM_RD_MULT = 4'b1100,
      CMD_MEM_RD_LINE = 4'b1110,
      CMD_MEM_WR_INV  = 4'b1111
   } pci_cmd_e;

   localparam int          LINE_W      = 8;
   localparam int          OFS_W       = 8;
   localparam logic [7:0]  OFS_LINE    = 8'h0C;
   localparam logic [7:0]  OFS_CLASS0  = 8'h09;
   localparam int          CLASS_BYTES = 3;
   localparam logic [23:0] CLASS_VALUE = 24'h010000;
endpackage

// File: rtl/pmcs_cfg_regs.sv
module pmcs_cfg_regs
   import pmcs_pkg::*;
#(
   parameter logic [8*CLASS_BYTES-1:0] CLASS_VAL = CLASS_VALUE
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [OFS_W-1:0]  cfg_ofs,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [LINE_W-1:0] line_words
);
   logic [7:0] lane [CLASS_BYTES+1];
   logic       line_hit;

   assign line_hit = (cfg_ofs == OFS_LINE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_words <= '0;
      else if (cfg_wr && line_hit)
         line_words <= cfg_wdata;
   end

   // one read lane per class code byte, unused lanes give zero
   genvar gi;
   generate
      for (gi = 0; gi < CLASS_BYTES; gi++) begin : g_class
         localparam logic [OFS_W-1:0] MY_OFS = OFS_CLASS0 + OFS_W'(gi);
         assign lane[gi] = (cfg_ofs == MY_OFS) ? CLASS_VAL[8*gi +: 8] : 8'h00;
      end
   endgenerate

   assign lane[CLASS_BYTES] = line_hit ? line_words : 8'h00;

   always_comb begin
      cfg_rdata = 8'h00;
      for (int i = 0; i <= CLASS_BYTES; i++)
         cfg_rdata = cfg_rdata | lane[i];
   end
endmodule

// File: rtl/pmcs_line_geom.sv
module pmcs_line_geom
   import pmcs_pkg::*;
#(
   parameter int POW2_IMPL = 0   // 0: bit trick, 1: population count
)(
   input  logic [LINE_W-1:0] line_words,
   input  logic [LINE_W-1:0] word_lo,
   output logic              caching,
   output logic              aligned,
   output logic [LINE_W:0]   room
);
   logic [LINE_W-1:0] lmask;
   logic [LINE_W-1:0] offset;

   assign lmask = line_words - LINE_W'(1);

   generate
      if (POW2_IMPL == 0) begin : g_trick
         assign caching = (line_words != '0) && ((line_words & lmask) == '0);
      end else begin : g_count
         logic [$clog2(LINE_W+1)-1:0] ones;
         always_comb begin
            ones = '0;
            for (int i = 0; i < LINE_W; i++)
               ones = ones + {{($clog2(LINE_W+1)-1){1'b0}}, line_words[i]};
         end
         assign caching = (ones == 1);
      end
   endgenerate

   assign offset  = word_lo & lmask;
   assign aligned = (offset == '0);
   assign room    = {1'b0, line_words} - {1'b0, offset};
endmodule

// File: rtl/pmcs_cmd_pick.sv
module pmcs_cmd_pick
   import pmcs_pkg::*;
#(
   parameter int LEN_W = 12
)(
   input  logic              caching,
   input  logic              aligned,
   input  logic [LINE_W:0]   room,
   input  logic [LINE_W-1:0] line_words,
   input  logic [LEN_W-1:0]  len,
   input  logic              is_write,
   output pci_cmd_e          cmd,
   output logic [LEN_W-1:0]  burst
);
   logic [LEN_W-1:0] room_l;
   logic [LEN_W-1:0] line_l;
   logic [LEN_W-1:0] whole;
   logic [LEN_W-1:0] to_edge;
   logic             fits;
   logic             full_line;

   assign room_l    = LEN_W'(room);
   assign line_l    = LEN_W'(line_words);
   assign whole     = len & ~(line_l - LEN_W'(1));
   assign fits      = (len <= room_l);
   assign to_edge   = fits ? len : room_l;
   assign full_line = (len >= line_l);

   always_comb begin
      cmd   = is_write ? CMD_MEM_WR : CMD_MEM_RD;
      burst = len;
      if (len == '0) begin
         burst = '0;
      end else if (caching) begin
         if (is_write) begin
            if (aligned && full_line) begin
               cmd   = CMD_MEM_WR_INV;
               burst = whole;
            end else begin
               burst = to_edge;
            end
         end else begin
            burst = to_edge;
            if (len == LEN_W'(1))
               cmd = CMD_MEM_RD;
            else if (fits)
               cmd = CMD_MEM_RD_LINE;
            else
               cmd = CMD_MEM_RD_MULT;
         end
      end
   end
endmodule

// File: rtl/pci_master_cmd_sel.sv
module pci_master_cmd_sel
   import pmcs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 12,
   parameter int POW2_IMPL = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_ofs,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_write,
   output logic [3:0]        cmd,
   output logic [LEN_W-1:0]  burst_len
);
   localparam int WORD_LSB = 2;

   generate
      if (ADDR_W < WORD_LSB + LINE_W) begin : g_bad_addr
         $error("ADDR_W too narrow for line offset");
      end
      if (LEN_W < LINE_W + 1) begin : g_bad_len
         $error("LEN_W must hold a full line count");
      end
      if (POW2_IMPL != 0 && POW2_IMPL != 1) begin : g_bad_impl
         $error("POW2_IMPL must be 0 or 1");
      end
   endgenerate

   logic [LINE_W-1:0] line_words;
   logic              caching;
   logic              aligned;
   logic [LINE_W:0]   room;
   pci_cmd_e          cmd_e;

   pmcs_cfg_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_ofs   (cfg_ofs),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .line_words(line_words)
   );

   pmcs_line_geom #(.POW2_IMPL(POW2_IMPL)) i_geom (
      .line_words(line_words),
      .word_lo   (req_addr[WORD_LSB +: LINE_W]),
      .caching   (caching),
      .aligned   (aligned),
      .room      (room)
   );

   pmcs_cmd_pick #(.LEN_W(LEN_W)) i_pick (
      .caching   (caching),
      .aligned   (aligned),
      .room      (room),
      .line_words(line_words),
      .len       (req_len),
      .is_write  (req_write),
      .cmd       (cmd_e),
      .burst     (burst_len)
   );

   assign cmd = cmd_e;
endmodule

// File: rtl/pmcs_checker.sv
module pmcs_checker #(
   parameter int LEN_W = 12
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [7:0]       cfg_ofs,
   input logic [7:0]       cfg_wdata,
   input logic [7:0]       cfg_rdata,
   input logic [7:0]       line_words,
   input logic [LEN_W-1:0] req_len,
   input logic             req_write,
   input logic [3:0]       cmd,
   input logic [LEN_W-1:0] burst_len
);
   // R1
   line_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_ofs == 8'h0C) |=> (line_words == $past(cfg_wdata)));

   // R3
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_ofs != 8'h0C) |=> $stable(line_words));

   // R2
   class_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ofs == 8'h0B) |-> (cfg_rdata == 8'h01));

   // R4
   basic_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(line_words) != 1) |-> (cmd == 4'b0110 || cmd == 4'b0111));

   // R5
   inval_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b1111) |-> (burst_len != '0 &&
         (burst_len & (LEN_W'(line_words) - LEN_W'(1))) == '0));

   // R6
   write_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_write |-> (cmd == 4'b0111 || cmd == 4'b1111));

   // R7
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_len <= req_len);

   // R8
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_len == '0) |-> (burst_len == '0 && (cmd == 4'b0110 || cmd == 4'b0111)));
endmodule

bind pci_master_cmd_sel pmcs_checker #(.LEN_W(LEN_W)) i_pmcs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_ofs   (cfg_ofs),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .line_words(line_words),
   .req_len   (req_len),
   .req_write (req_write),
   .cmd       (cmd),
   .burst_len (burst_len)
);

// File: tb/test_pci_master_cmd_sel.sv
module test_pci_master_cmd_sel;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int LW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [7:0]    cfg_ofs = '0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          req_write = 1'b0;
   logic [3:0]    cmd;
   logic [LW-1:0] burst_len;

   int n_run = 0;
   int n_fail = 0;
   int cur_line = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_master_cmd_sel i_pci_master_cmd_sel (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
      .req_len(req_len), .req_write(req_write), .cmd(cmd), .burst_len(burst_len)
   );

   function automatic logic [15:0] model(int line, int waddr, int len, bit wr);
      int off, room, b;
      logic [3:0] c;
      bit pow;
      pow = (line != 0) && ((line & (line - 1)) == 0);
      c = wr ? 4'b0111 : 4'b0110;
      b = len;
      if (len != 0 && pow) begin
         off  = waddr % line;
         room = line - off;
         if (wr) begin
            if (off == 0 && len >= line) begin
               c = 4'b1111;
               b = (len / line) * line;
            end else begin
               b = (len < room) ? len : room;
            end
         end else begin
            b = (len < room) ? len : room;
            if (len == 1) c = 4'b0110;
            else if (len <= room) c = 4'b1110;
            else c = 4'b1100;
         end
      end
      return {c, 12'(b)};
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(logic [7:0] ofs, logic [7:0] val);
      @(negedge clk);
      cfg_ofs = ofs; cfg_wdata = val; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (ofs == 8'h0C) cur_line = val;
   endtask

   task automatic cfg_check(string req, logic [7:0] ofs, logic [7:0] exp);
      @(negedge clk);
      cfg_ofs = ofs;
      #1;
      check(req, {8'h00, cfg_rdata}, {8'h00, exp});
   endtask

   task automatic req_check(string req, logic [AW-1:0] addr, int len, bit wr);
      @(negedge clk);
      req_addr = addr; req_len = LW'(len); req_write = wr;
      #1;
      check(req, {cmd, burst_len}, model(cur_line, int'(addr[AW-1:2] & 32'h3FFFFFFF), len, wr));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'h5EED_1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset value
      cfg_check("R1 reset", 8'h0C, 8'h00);
      // R2 class code bytes and unused offsets
      cfg_check("R2 base", 8'h0B, 8'h01);
      cfg_check("R2 sub", 8'h0A, 8'h00);
      cfg_check("R2 progif", 8'h09, 8'h00);
      cfg_check("R2 unused", 8'h0D, 8'h00);
      cfg_check("R2 unused low", 8'h08, 8'h00);
      // R4 line size zero: basic commands, unsplit
      req_check("R4 zero line wr", 32'h0000_0000, 40, 1'b1);
      req_check("R4 zero line rd", 32'h0000_0004, 40, 1'b0);
      // R1 write and readback
      cfg_write(8'h0C, 8'h08);
      cfg_check("R1 readback", 8'h0C, 8'h08);
      // R3 writes to read-only offsets
      cfg_write(8'h0B, 8'hAA);
      cfg_write(8'h0D, 8'h55);
      cfg_check("R3 line kept", 8'h0C, 8'h08);
      cfg_check("R3 class kept", 8'h0B, 8'h01);
      // R5 aligned write with leftover
      req_check("R5 mwi", 32'h0000_0100, 19, 1'b1);
      req_check("R5 mwi exact", 32'h0000_0100, 8, 1'b1);
      // R6 misaligned and short writes
      req_check("R6 misaligned", 32'h0000_0104, 19, 1'b1);
      req_check("R6 short aligned", 32'h0000_0100, 7, 1'b1);
      // R7 read boundary edges, offset 3 words: room 5
      req_check("R7 single", 32'h0000_010C, 1, 1'b0);
      req_check("R7 line at edge", 32'h0000_010C, 5, 1'b0);
      req_check("R7 multiple past", 32'h0000_010C, 6, 1'b0);
      req_check("R7 line inside", 32'h0000_010C, 2, 1'b0);
      // R8 zero length
      req_check("R8 zero rd", 32'h0000_0100, 0, 1'b0);
      req_check("R8 zero wr", 32'h0000_0100, 0, 1'b1);
      // R9 low address bits ignored
      req_check("R9 low bits", 32'h0000_0103, 19, 1'b1);
      req_check("R9 low bits rd", 32'h0000_010F, 6, 1'b0);
      // R4 non-power-of-two
      cfg_write(8'h0C, 8'h0C);
      req_check("R4 npow2 wr", 32'h0000_0000, 30, 1'b1);
      req_check("R4 npow2 rd", 32'h0000_0010, 30, 1'b0);

      // directed edges per legal line size
      for (int s = 0; s < 8; s++) begin
         int line;
         line = 1 << s;
         cfg_write(8'h0C, 8'(line));
         for (int k = 0; k < 4; k++) begin
            int off, room;
            off  = (line > 1) ? ((k + 1) % line) : 0;
            room = line - off;
            req_check("R7 edge", AW'((64 * 256 + off) * 4), room, 1'b0);
            req_check("R7 edge+1", AW'((64 * 256 + off) * 4), room + 1, 1'b0);
            req_check("R6 edge-1", AW'((64 * 256 + off) * 4), room - 1 + (room == 1 ? 1 : 0), 1'b1);
            req_check("R5 full", AW'(64 * 256 * 4), line * (k + 1) + k, 1'b1);
         end
      end

      // random mix
      for (int it = 0; it < 600; it++) begin
         int pick;
         logic [7:0] lv;
         if (it % 20 == 0) begin
            pick = int'($urandom_range(0, 3));
            if (pick == 0) lv = 8'($urandom_range(0, 255));
            else lv = 8'(1 << $urandom_range(0, 7));
            cfg_write(8'h0C, lv);
         end
         req_check("R4-7 rand", AW'($urandom), int'($urandom_range(0, 300)), 1'($urandom));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule